// File: doc/BRIEF.md
# Double-Precision Result Rounder with Exception Flags

This block sits at the end of a floating-point datapath. It takes an unrounded intermediate value and turns it into a final IEEE double-precision word. The intermediate value has a sign, a signed unbiased exponent wider than the output field, a 53-bit significand with its hidden bit at the top, and three discarded bits (guard, round, sticky). Three class inputs mark zero, infinity and NaN results, and a further input reports that a denormalized operand took part in the operation.

The block works through three stages in a fixed order. It first tests for underflow, then rounds in one of four modes, then tests for overflow. It raises the underflow, overflow and inexact flags. It also produces a 4-bit condition code, ordered N, Z, I, NAN from bit 3 down to bit 0, and it derives that code from the final word alone. The logic is combinational and ends in one register stage, so a result appears one cycle after its valid input.

Top module: `fp_round_flag`

## Requirements
- R1: When the biased exponent (unbiased exponent plus 1023) of a non-special input is below 1, the block raises the underflow flag and returns a zero that carries the input's sign.
- R2: Rounding mode `in_rmode` uses this encoding: 00 nearest-even (round up when guard=1 and round, sticky or LSB is 1), 01 toward zero (truncate), 10 toward minus infinity (round up the magnitude only for negative values with any discarded bit set), 11 toward plus infinity (round up the magnitude only for positive values with any discarded bit set).
- R3: When rounding carries out of the significand, the block shifts it right one place and adds one to the exponent before the overflow test.
- R4: The inexact flag is raised when any of the guard, round or sticky bits of a non-special input is 1.
- R5: When the rounded biased exponent reaches 2047 or more, the block raises the overflow flag. Overflow and underflow never occur together.
- R6: On overflow the result is a signed infinity in nearest-even mode, and also in a directed mode that rounds away from zero for that sign. In every other case the result is the signed largest normal number (exponent 2046, fraction all ones).
- R7: The inexact flag is also raised whenever overflow or underflow is raised, and whenever `in_denorm` is high.
- R8: The condition code takes N from the result's sign bit. Z marks zero (+0 gives 0100, -0 gives 1100), I marks infinity (+inf gives 0010, -inf gives 1010), and a nonzero finite value has Z, I and NAN clear. At most one of Z, I and NAN is set.
- R9: A NaN input gives the quiet NaN 0x7FF8000000000000 with the input sign in bit 63, and the condition code has NAN set and N equal to the sign.
- R10: A zero, infinity or NaN input passes through with no underflow or overflow flag, and its discarded bits are ignored.
- R11: Outputs are registered. `out_valid` follows `in_valid` one cycle later, and reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Intermediate value is present |
| in_sign | input | 1 | Sign of the intermediate value |
| in_exp | input | 13 | Signed unbiased exponent |
| in_man | input | 53 | Significand, hidden bit at bit 52 |
| in_grs | input | 3 | Guard (bit 2), round (bit 1), sticky (bit 0) |
| in_zero | input | 1 | Intermediate value is zero |
| in_inf | input | 1 | Intermediate value is infinity |
| in_nan | input | 1 | Intermediate value is NaN |
| in_denorm | input | 1 | A denormalized operand was used |
| in_rmode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result is valid |
| out_result | output | 64 | Double-precision result |
| out_unfl | output | 1 | Underflow flag |
| out_ovfl | output | 1 | Overflow flag |
| out_inex | output | 1 | Inexact flag |
| out_cc | output | 4 | Condition code {N, Z, I, NAN} |

## Verification
The assertions check on every cycle the properties that hold for any input. Valid follows one cycle after its input. Overflow and underflow are mutually exclusive. Either flag forces inexact. An underflowed word is a signed zero. An overflowed word is either infinity or the largest normal number. At most one of Z, I and NAN is set. Only the directed scenarios can show the exact rounding decision in each mode, including ties, carry renormalization and mode-selected overflow values. They also cover the exponent boundaries on both sides of underflow and overflow, and the condition code for each result class.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_ZERO = 2'b01,
      RM_DOWN = 2'b10,
      RM_UP   = 2'b11
   } rmode_e;
endpackage

// File: rtl/fpr_round.sv
module fpr_round
   import fpr_pkg::*;
#(
   parameter int FRAC_W = 52
) (
   input  logic              sign,
   input  logic [1:0]        rmode,
   input  logic [FRAC_W:0]   man,
   input  logic [2:0]        grs,
   output logic [FRAC_W-1:0] frac,
   output logic              carry,
   output logic              lost
);
   localparam int SUM_W = FRAC_W + 2;

   logic             bump;
   logic [SUM_W-1:0] sum;

   always_comb begin
      lost = |grs;
      case (rmode_e'(rmode))
         RM_NEAR: bump = grs[2] & (grs[1] | grs[0] | man[0]);
         RM_ZERO: bump = 1'b0;
         RM_DOWN: bump = sign & lost;
         default: bump = ~sign & lost;
      endcase
      sum   = {1'b0, man} + {{(SUM_W-1){1'b0}}, bump};
      carry = sum[SUM_W-1];
      frac  = carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/fpr_range.sv
module fpr_range
   import fpr_pkg::*;
#(
   parameter int EXP_W     = 13,
   parameter int FRAC_W    = 52,
   parameter int RES_EXP_W = 11,
   localparam int RES_W    = 1 + RES_EXP_W + FRAC_W
) (
   input  logic              sign,
   input  logic [EXP_W-1:0]  exp_in,
   input  logic [1:0]        rmode,
   input  logic              is_zero,
   input  logic              is_inf,
   input  logic              is_nan,
   input  logic              denorm_src,
   input  logic [FRAC_W-1:0] frac,
   input  logic              carry,
   input  logic              lost,
   output logic [RES_W-1:0]  result,
   output logic              unfl,
   output logic              ovfl,
   output logic              inex
);
   localparam int EW   = EXP_W + 1;
   localparam int BIAS = 2 ** (RES_EXP_W - 1) - 1;
   localparam int EMAX = 2 ** RES_EXP_W - 1;
   localparam logic signed [EW-1:0] ONE_S  = EW'(1);
   localparam logic signed [EW-1:0] EMAX_S = EW'(EMAX);
   localparam logic [RES_EXP_W-1:0] EXP_ONES = {RES_EXP_W{1'b1}};
   localparam logic [RES_EXP_W-1:0] EXP_TOP  = EXP_ONES - RES_EXP_W'(1);

   logic signed [EW-1:0] bexp, bexp_r;
   logic special, to_inf;

   always_comb begin
      bexp    = {exp_in[EXP_W-1], exp_in} + EW'(BIAS);
      bexp_r  = bexp + {{(EW-1){1'b0}}, carry};
      special = is_zero | is_inf | is_nan;
      unfl    = ~special & (bexp < ONE_S);
      ovfl    = ~special & ~unfl & (bexp_r >= EMAX_S);
      to_inf  = (rmode_e'(rmode) == RM_NEAR) |
                ((rmode_e'(rmode) == RM_DOWN) & sign) |
                ((rmode_e'(rmode) == RM_UP) & ~sign);
      inex    = denorm_src | (~special & (lost | unfl | ovfl));

      if (is_nan)
         result = {sign, EXP_ONES, 1'b1, {(FRAC_W-1){1'b0}}};
      else if (is_inf)
         result = {sign, EXP_ONES, {FRAC_W{1'b0}}};
      else if (is_zero || unfl)
         result = {sign, {(RES_W-1){1'b0}}};
      else if (ovfl)
         result = to_inf ? {sign, EXP_ONES, {FRAC_W{1'b0}}}
                         : {sign, EXP_TOP, {FRAC_W{1'b1}}};
      else
         result = {sign, bexp_r[RES_EXP_W-1:0], frac};
   end
endmodule

// File: rtl/fpr_ccode.sv
module fpr_ccode #(
   parameter int FRAC_W    = 52,
   parameter int RES_EXP_W = 11,
   localparam int RES_W    = 1 + RES_EXP_W + FRAC_W
) (
   input  logic [RES_W-1:0] result,
   output logic [3:0]       cc
);
   logic exp_ones, exp_zero, frac_nz;

   always_comb begin
      exp_ones = &result[FRAC_W +: RES_EXP_W];
      exp_zero = ~|result[FRAC_W +: RES_EXP_W];
      frac_nz  = |result[FRAC_W-1:0];
      cc = {result[RES_W-1],
            exp_zero & ~frac_nz,
            exp_ones & ~frac_nz,
            exp_ones & frac_nz};
   end
endmodule

// File: rtl/fp_round_flag.sv
module fp_round_flag #(
   parameter int EXP_W     = 13,
   parameter int FRAC_W    = 52,
   parameter int RES_EXP_W = 11,
   localparam int RES_W    = 1 + RES_EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sign,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [FRAC_W:0]   in_man,
   input  logic [2:0]        in_grs,
   input  logic              in_zero,
   input  logic              in_inf,
   input  logic              in_nan,
   input  logic              in_denorm,
   input  logic [1:0]        in_rmode,
   output logic              out_valid,
   output logic [RES_W-1:0]  out_result,
   output logic              out_unfl,
   output logic              out_ovfl,
   output logic              out_inex,
   output logic [3:0]        out_cc
);
   localparam logic [RES_EXP_W-1:0] EXP_ONES = {RES_EXP_W{1'b1}};
   localparam logic [RES_EXP_W-1:0] EXP_TOP  = EXP_ONES - RES_EXP_W'(1);

   if (EXP_W <= RES_EXP_W) begin : g_bad_exp
      $error("EXP_W must exceed RES_EXP_W");
   end
   if (FRAC_W < 2 || RES_EXP_W < 2) begin : g_bad_fmt
      $error("FRAC_W and RES_EXP_W must be at least 2");
   end

   logic [FRAC_W-1:0] r_frac;
   logic              r_carry, r_lost;
   logic [RES_W-1:0]  n_result;
   logic              n_unfl, n_ovfl, n_inex;
   logic [3:0]        n_cc;

   fpr_round #(.FRAC_W(FRAC_W)) u_round (
      .sign(in_sign), .rmode(in_rmode), .man(in_man), .grs(in_grs),
      .frac(r_frac), .carry(r_carry), .lost(r_lost)
   );

   fpr_range #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .RES_EXP_W(RES_EXP_W)) u_range (
      .sign(in_sign), .exp_in(in_exp), .rmode(in_rmode),
      .is_zero(in_zero), .is_inf(in_inf), .is_nan(in_nan),
      .denorm_src(in_denorm), .frac(r_frac), .carry(r_carry), .lost(r_lost),
      .result(n_result), .unfl(n_unfl), .ovfl(n_ovfl), .inex(n_inex)
   );

   fpr_ccode #(.FRAC_W(FRAC_W), .RES_EXP_W(RES_EXP_W)) u_cc (
      .result(n_result), .cc(n_cc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_result <= '0;
         out_unfl   <= 1'b0;
         out_ovfl   <= 1'b0;
         out_inex   <= 1'b0;
         out_cc     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result <= n_result;
            out_unfl   <= n_unfl;
            out_ovfl   <= n_ovfl;
            out_inex   <= n_inex;
            out_cc     <= n_cc;
         end
      end
   end

   // R11
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R5
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_ovfl && out_unfl));

   // R7
   inex_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ovfl || out_unfl) |-> out_inex);

   // R1
   unfl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_unfl |-> (out_result[RES_W-2:0] == '0 && out_cc[2]));

   // R6
   ovfl_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovfl |-> ((out_result[FRAC_W +: RES_EXP_W] == EXP_ONES &&
                     out_result[FRAC_W-1:0] == '0) ||
                    (out_result[FRAC_W +: RES_EXP_W] == EXP_TOP &&
                     &out_result[FRAC_W-1:0])));

   // R8
   cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_cc[2:0]) && (out_cc[3] == out_result[RES_W-1]));
endmodule

// File: tb/fp_round_flag_test.sv
module fp_round_flag_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid, in_sign, in_zero, in_inf, in_nan, in_denorm;
   logic [12:0] in_exp;
   logic [52:0] in_man;
   logic [2:0]  in_grs;
   logic [1:0]  in_rmode;
   logic        out_valid, out_unfl, out_ovfl, out_inex;
   logic [63:0] out_result;
   logic [3:0]  out_cc;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [52:0] ONE = 53'h10_0000_0000_0000;
   localparam logic [52:0] ALL = 53'h1F_FFFF_FFFF_FFFF;

   always #2 clk = ~clk;

   fp_round_flag uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_exp(in_exp), .in_man(in_man), .in_grs(in_grs), .in_zero(in_zero),
      .in_inf(in_inf), .in_nan(in_nan), .in_denorm(in_denorm),
      .in_rmode(in_rmode), .out_valid(out_valid), .out_result(out_result),
      .out_unfl(out_unfl), .out_ovfl(out_ovfl), .out_inex(out_inex),
      .out_cc(out_cc)
   );

   task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive one value, then sample after the registering edge
   task automatic apply(input logic s, input int e, input logic [52:0] m,
                        input logic [2:0] g, input logic [1:0] rm,
                        input logic z, input logic i, input logic n, input logic d);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = 13'(e); in_man = m; in_grs = g;
      in_rmode = rm; in_zero = z; in_inf = i; in_nan = n; in_denorm = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // flags packed {valid, unfl, ovfl, inex}
   task automatic expect_out(input string tag, input logic [63:0] res,
                             input logic [2:0] uox, input logic [3:0] cc);
      check(tag, {out_valid, out_unfl, out_ovfl, out_inex, out_cc, out_result},
            {1'b1, uox, cc, res});
   endtask

   task automatic t_reset;
      check("R11 reset", {out_valid, out_unfl, out_ovfl, out_inex, out_cc, out_result}, 72'h0);
   endtask

   task automatic t_exact;
      apply(0, 0, ONE, 3'b000, 2'b00, 0, 0, 0, 0);
      expect_out("R8 +1.0", 64'h3FF0000000000000, 3'b000, 4'b0000);
      apply(1, 0, ONE, 3'b000, 2'b00, 0, 0, 0, 0);
      expect_out("R8 -1.0", 64'hBFF0000000000000, 3'b000, 4'b1000);
   endtask

   task automatic t_nearest;
      apply(0, 0, ONE, 3'b100, 2'b00, 0, 0, 0, 0);
      expect_out("R2 R4 tie even", 64'h3FF0000000000000, 3'b001, 4'b0000);
      apply(0, 0, ONE | 53'd1, 3'b100, 2'b00, 0, 0, 0, 0);
      expect_out("R2 tie odd", 64'h3FF0000000000002, 3'b001, 4'b0000);
      apply(0, 0, ONE, 3'b101, 2'b00, 0, 0, 0, 0);
      expect_out("R2 above half", 64'h3FF0000000000001, 3'b001, 4'b0000);
   endtask

   task automatic t_directed;
      apply(0, 0, ONE | 53'd1, 3'b111, 2'b01, 0, 0, 0, 0);
      expect_out("R2 toward zero", 64'h3FF0000000000001, 3'b001, 4'b0000);
      apply(0, 0, ONE, 3'b010, 2'b10, 0, 0, 0, 0);
      expect_out("R2 down pos", 64'h3FF0000000000000, 3'b001, 4'b0000);
      apply(1, 0, ONE, 3'b010, 2'b10, 0, 0, 0, 0);
      expect_out("R2 down neg", 64'hBFF0000000000001, 3'b001, 4'b1000);
      apply(0, 0, ONE, 3'b001, 2'b11, 0, 0, 0, 0);
      expect_out("R2 up pos", 64'h3FF0000000000001, 3'b001, 4'b0000);
      apply(1, 0, ONE, 3'b001, 2'b11, 0, 0, 0, 0);
      expect_out("R2 up neg", 64'hBFF0000000000000, 3'b001, 4'b1000);
   endtask

   task automatic t_carry;
      apply(0, 0, ALL, 3'b110, 2'b00, 0, 0, 0, 0);
      expect_out("R3 carry renorm", 64'h4000000000000000, 3'b001, 4'b0000);
   endtask

   task automatic t_overflow;
      apply(0, 1023, ALL, 3'b000, 2'b00, 0, 0, 0, 0);
      expect_out("R5 max exact", 64'h7FEFFFFFFFFFFFFF, 3'b000, 4'b0000);
      apply(0, 1023, ALL, 3'b100, 2'b00, 0, 0, 0, 0);
      expect_out("R5 R3 carry ovfl", 64'h7FF0000000000000, 3'b011, 4'b0010);
      apply(0, 1023, ALL, 3'b100, 2'b01, 0, 0, 0, 0);
      expect_out("R6 zero no ovfl", 64'h7FEFFFFFFFFFFFFF, 3'b001, 4'b0000);
      apply(1, 2000, ONE, 3'b000, 2'b01, 0, 0, 0, 0);
      expect_out("R6 zero neg", 64'hFFEFFFFFFFFFFFFF, 3'b011, 4'b1000);
      apply(1, 2000, ONE, 3'b000, 2'b10, 0, 0, 0, 0);
      expect_out("R6 down neg", 64'hFFF0000000000000, 3'b011, 4'b1010);
      apply(0, 2000, ONE, 3'b000, 2'b10, 0, 0, 0, 0);
      expect_out("R6 down pos", 64'h7FEFFFFFFFFFFFFF, 3'b011, 4'b0000);
      apply(0, 1024, ONE, 3'b000, 2'b11, 0, 0, 0, 0);
      expect_out("R6 up pos", 64'h7FF0000000000000, 3'b011, 4'b0010);
      apply(1, 1024, ONE, 3'b000, 2'b11, 0, 0, 0, 0);
      expect_out("R6 up neg", 64'hFFEFFFFFFFFFFFFF, 3'b011, 4'b1000);
   endtask

   task automatic t_underflow;
      apply(0, -1023, ALL, 3'b000, 2'b00, 0, 0, 0, 0);
      expect_out("R1 R7 unfl pos", 64'h0000000000000000, 3'b101, 4'b0100);
      apply(1, -3000, ONE, 3'b000, 2'b11, 0, 0, 0, 0);
      expect_out("R1 unfl neg", 64'h8000000000000000, 3'b101, 4'b1100);
      apply(0, -1022, ONE, 3'b000, 2'b00, 0, 0, 0, 0);
      expect_out("R1 min normal", 64'h0010000000000000, 3'b000, 4'b0000);
   endtask

   task automatic t_special;
      apply(1, 0, ALL, 3'b111, 2'b00, 1, 0, 0, 0);
      expect_out("R10 R8 neg zero", 64'h8000000000000000, 3'b000, 4'b1100);
      apply(0, 0, ONE, 3'b000, 2'b00, 1, 0, 0, 1);
      expect_out("R7 zero denorm", 64'h0000000000000000, 3'b001, 4'b0100);
      apply(1, 0, ONE, 3'b000, 2'b00, 0, 1, 0, 0);
      expect_out("R8 neg inf", 64'hFFF0000000000000, 3'b000, 4'b1010);
      apply(0, 2000, ALL, 3'b111, 2'b11, 0, 1, 0, 0);
      expect_out("R10 pos inf", 64'h7FF0000000000000, 3'b000, 4'b0010);
      apply(1, 0, ONE, 3'b000, 2'b00, 0, 0, 1, 0);
      expect_out("R9 neg nan", 64'hFFF8000000000000, 3'b000, 4'b1001);
      apply(0, -3000, ONE, 3'b101, 2'b00, 0, 0, 1, 0);
      expect_out("R9 pos nan", 64'h7FF8000000000000, 3'b000, 4'b0001);
      apply(0, 0, ONE, 3'b000, 2'b00, 0, 0, 0, 1);
      expect_out("R7 denorm src", 64'h3FF0000000000000, 3'b001, 4'b0000);
   endtask

   task automatic t_valid;
      apply(0, 0, ONE, 3'b000, 2'b00, 0, 0, 0, 0);
      @(negedge clk);
      check("R11 valid drops", {71'h0, out_valid}, 72'h0);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0; in_man = '0;
      in_grs = '0; in_zero = 1'b0; in_inf = 1'b0; in_nan = 1'b0;
      in_denorm = 1'b0; in_rmode = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_exact();
      t_nearest();
      t_directed();
      t_carry();
      t_overflow();
      t_underflow();
      t_special();
      t_valid();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule